// File: doc/BRIEF.md
# Peripheral-to-Channel Tree Lookup

This block turns a 12-bit peripheral identifier into an 8-bit channel number. The identifier is formed from a 4-bit slave ID and an 8-bit peripheral number. The translation follows a programmable binary decision tree held in an internal table of 32-bit nodes. Each node names one identifier bit to test. The value of that bit picks one of two branches, and each branch yields either the index of the next node or the final channel number.

Found answers are remembered in a per-identifier result cache, so a repeated lookup is answered without walking the tree. Any write to the node table discards every cached answer, because an answer may depend on any node. Requests use a ready/valid handshake and are taken only while the block is idle. Each accepted request produces exactly one single-cycle response that carries a found flag and the channel number.

Top module: `chan_lookup`

## Requirements
- R1: After synchronous reset, rsp_valid is 0 and req_ready is 1.
- R2: The identifier is {req_sid, req_per}, with req_sid in bits 11:8 and req_per in bits 7:0. A node tests identifier bit i for i = 0..11; a selector of 12 to 15 reads as 0.
- R3: Node word layout: bits 21:18 are the bit selector, bit 17 is the zero-branch chain flag, bits 16:9 are the zero-branch result, bit 8 is the one-branch chain flag, and bits 7:0 are the one-branch result. Bits 31:22 are ignored.
- R4: On the taken branch, a set chain flag makes the result the next node index. A clear chain flag makes the result the final channel, and the block answers with rsp_found=1.
- R5: The walk starts at node 0 and visits one node per cycle. An uncached lookup that visits n nodes raises rsp_valid 1+n cycles after the accepting edge.
- R6: If 16 visited nodes all chain onward, the lookup fails with rsp_found=0 and rsp_chan=0, 17 cycles after acceptance. A walk that ends on the 16th node still succeeds.
- R7: A found answer is cached. A later request for the same identifier gives the same channel with rsp_valid one cycle after acceptance.
- R8: Failed lookups are not cached. Repeating one walks the tree again with the same latency.
- R9: Writing any node table entry invalidates all cached answers.
- R10: If a table write occurs while a request is in flight, that request's answer is not cached.
- R11: req_ready is 1 only when idle. A request is taken on req_valid && req_ready. Requests presented while busy are ignored, and each accepted request yields exactly one response.
- R12: rsp_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_sid | input | 4 | Slave ID, identifier bits 11:8 |
| req_per | input | 8 | Peripheral number, identifier bits 7:0 |
| rsp_valid | output | 1 | Response pulse |
| rsp_found | output | 1 | 1 = channel found, 0 = lookup failed |
| rsp_chan | output | 8 | Channel number (0 on failure) |
| tbl_we | input | 1 | Node table write strobe |
| tbl_addr | input | TBL_AW | Node table write index |
| tbl_wdata | input | 32 | Node word to write |

## Verification
A stale or missing cache entry shows at the response port as a wrong latency. The answer comes one cycle after acceptance instead of 1+n, or the reverse. An error in branch decoding or in the selected bit shows as a wrong channel or found flag on the very next response. The bench therefore checks the response cycle count of every request against a reference walk and a reference cache model. It does this for directed trees (deep chains, an exact 16-node walk, a self-loop, selectors above bit 11) and for random trees with table rewrites mixed in, so a fault appears within one request.

// File: rtl/chl_pkg.sv
package chl_pkg;
  localparam int SID_W  = 4;
  localparam int PER_W  = 8;
  localparam int ID_W   = SID_W + PER_W;
  localparam int CH_W   = 8;
  localparam int NODE_W = 32;

  // node word field positions
  localparam int SEL_HI = 21;
  localparam int SEL_LO = 18;
  localparam int F0_BIT = 17;
  localparam int R0_HI  = 16;
  localparam int R0_LO  = 9;
  localparam int F1_BIT = 8;
  localparam int R1_HI  = 7;
  localparam int R1_LO  = 0;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_LOOK = 2'd1,
    S_WALK = 2'd2
  } st_t;
endpackage

// File: rtl/chl_sdp_ram.sv
module chl_sdp_ram #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chl_node_eval.sv
module chl_node_eval
  import chl_pkg::*;
(
  input  logic [NODE_W-1:0] node,
  input  logic [ID_W-1:0]   id,
  output logic              chain,
  output logic [CH_W-1:0]   result
);
  localparam int SEL_W = SEL_HI - SEL_LO + 1;
  localparam int WIDE  = 1 << SEL_W;

  logic [WIDE-1:0]  id_wide;
  logic [SEL_W-1:0] sel;
  logic             tested;

  always_comb begin
    id_wide = WIDE'(id);
    sel     = node[SEL_HI:SEL_LO];
    tested  = id_wide[sel];
    if (tested) begin
      chain  = node[F1_BIT];
      result = node[R1_HI:R1_LO];
    end else begin
      chain  = node[F0_BIT];
      result = node[R0_HI:R0_LO];
    end
  end
endmodule

// File: rtl/chl_hit_cache.sv
module chl_hit_cache #(
  parameter int IW = 12,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inv,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_id,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_id,
  input  logic [CW-1:0] wr_chan,
  output logic          hit,
  output logic [CW-1:0] chan
);
  localparam int ENTRIES = 1 << IW;

  logic [ENTRIES-1:0] live_q;
  logic               hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      if (inv)        live_q <= '0;
      else if (wr_en) live_q[wr_id] <= 1'b1;
      if (rd_en)      hit_q <= live_q[rd_id] && !inv;
    end
  end

  chl_sdp_ram #(.DW(CW), .AW(IW)) u_data (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_id),
    .wdata (wr_chan),
    .re    (rd_en),
    .raddr (rd_id),
    .rdata (chan)
  );

  assign hit = hit_q;
endmodule

// File: rtl/chan_lookup.sv
module chan_lookup #(
  parameter int TBL_AW    = 8,
  parameter int MAX_STEPS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [chl_pkg::SID_W-1:0] req_sid,
  input  logic [chl_pkg::PER_W-1:0] req_per,
  output logic                      rsp_valid,
  output logic                      rsp_found,
  output logic [chl_pkg::CH_W-1:0]  rsp_chan,
  input  logic                      tbl_we,
  input  logic [TBL_AW-1:0]         tbl_addr,
  input  logic [chl_pkg::NODE_W-1:0] tbl_wdata
);
  import chl_pkg::*;

  localparam int STEP_W = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);

  st_t               state_q;
  logic [ID_W-1:0]   id_q;
  logic [STEP_W-1:0] step_q;
  logic              dirty_q;

  logic              accept;
  logic              c_hit;
  logic [CH_W-1:0]   c_chan;
  logic              use_hit;
  logic [NODE_W-1:0] node_q;
  logic              ev_chain;
  logic [CH_W-1:0]   ev_res;
  logic              t_re;
  logic [TBL_AW-1:0] t_raddr;
  logic              fill_en;
  logic              last_step;

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign use_hit   = c_hit && !tbl_we;
  assign last_step = (step_q == LAST_STEP);
  assign fill_en   = (state_q == S_WALK) && !ev_chain && !dirty_q && !tbl_we;

  always_comb begin
    t_re    = 1'b0;
    t_raddr = '0;
    if (state_q == S_LOOK && !use_hit) begin
      t_re = 1'b1;
    end else if (state_q == S_WALK && ev_chain && !last_step) begin
      t_re    = 1'b1;
      t_raddr = TBL_AW'(ev_res);
    end
  end

  chl_sdp_ram #(.DW(NODE_W), .AW(TBL_AW)) u_tree (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wdata (tbl_wdata),
    .re    (t_re),
    .raddr (t_raddr),
    .rdata (node_q)
  );

  chl_node_eval u_eval (
    .node   (node_q),
    .id     (id_q),
    .chain  (ev_chain),
    .result (ev_res)
  );

  chl_hit_cache #(.IW(ID_W), .CW(CH_W)) u_cache (
    .clk     (clk),
    .rst     (rst),
    .inv     (tbl_we),
    .rd_en   (accept),
    .rd_id   ({req_sid, req_per}),
    .wr_en   (fill_en),
    .wr_id   (id_q),
    .wr_chan (ev_res),
    .hit     (c_hit),
    .chan    (c_chan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      id_q      <= '0;
      step_q    <= '0;
      dirty_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_found <= 1'b0;
      rsp_chan  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (tbl_we && state_q != S_IDLE) dirty_q <= 1'b1;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            id_q    <= {req_sid, req_per};
            dirty_q <= 1'b0;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (use_hit) begin
            rsp_valid <= 1'b1;
            rsp_found <= 1'b1;
            rsp_chan  <= c_chan;
            state_q   <= S_IDLE;
          end else begin
            step_q  <= '0;
            state_q <= S_WALK;
          end
        end
        S_WALK: begin
          if (!ev_chain) begin
            rsp_valid <= 1'b1;
            rsp_found <= 1'b1;
            rsp_chan  <= ev_res;
            state_q   <= S_IDLE;
          end else if (last_step) begin
            rsp_valid <= 1'b1;
            rsp_found <= 1'b0;
            rsp_chan  <= '0;
            state_q   <= S_IDLE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chl_checker.sv
module chl_checker #(
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_found,
  input logic [7:0]        rsp_chan,
  input logic              walking,
  input logic [STEP_W-1:0] step
);
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_busy_after_take_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_rsp_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> req_ready);

  p_fail_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_found) |-> (rsp_chan == 8'd0));

  p_step_advance_r5: assert property (@(posedge clk) disable iff (rst)
    (walking && $past(walking) && !$past(rst)) |-> (step == $past(step) + 1'b1));
endmodule

bind chan_lookup chl_checker #(.STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_found (rsp_found),
  .rsp_chan  (rsp_chan),
  .walking   (state_q == chl_pkg::S_WALK),
  .step      (step_q)
);

// File: tb/chan_lookup_tb.sv
module chan_lookup_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_sid = '0;
  logic [7:0]  req_per = '0;
  logic        rsp_valid;
  logic        rsp_found;
  logic [7:0]  rsp_chan;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;

  int total = 0;
  int bad = 0;

  logic [31:0] tbl_m [256];
  bit          cv_m  [4096];
  logic [7:0]  cc_m  [4096];

  always #4 clk = ~clk;

  chan_lookup u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_sid(req_sid), .req_per(req_per), .rsp_valid(rsp_valid),
    .rsp_found(rsp_found), .rsp_chan(rsp_chan), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
  );

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int sel, input bit f0, input int r0,
                                     input bit f1, input int r1);
    return {10'd0, 4'(sel), f0, 8'(r0), f1, 8'(r1)};
  endfunction

  function automatic void ref_walk(input logic [11:0] id, output bit fnd,
                                   output logic [7:0] ch, output int n);
    logic [7:0] idx = 8'd0;
    fnd = 1'b0; ch = 8'd0; n = 0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] e = tbl_m[idx];
      int  b = int'(e[21:18]);
      bit  t = (b < 12) ? id[b] : 1'b0;
      bit  f = t ? e[8] : e[17];
      logic [7:0] r = t ? e[7:0] : e[16:9];
      n++;
      if (!f) begin fnd = 1'b1; ch = r; break; end
      idx = r;
    end
  endfunction

  task automatic twrite(input int a, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 8'(a); tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_m[a] = d;
    for (int i = 0; i < 4096; i++) cv_m[i] = 1'b0;
  endtask

  // poke: table write to entry 255 while walking; noise: other request held while busy
  task automatic run_req(input logic [3:0] s, input logic [7:0] p, input bit poke,
                         input bit noise, input string req);
    logic [11:0] id = {s, p};
    bit          e_f;
    logic [7:0]  e_c;
    int          n;
    int          e_lat;
    int          lat = 0;
    bit          got = 1'b0;
    bit          busy_ok = 1'b1;
    if (cv_m[id]) begin
      e_f = 1'b1; e_c = cc_m[id]; e_lat = 1;
    end else begin
      ref_walk(id, e_f, e_c, n);
      e_lat = 1 + n;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_sid = s; req_per = p;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin req_sid = ~s; req_per = ~p; end
    else req_valid = 1'b0;
    while (lat < 40) begin
      if (poke && lat == 1) begin tbl_we = 1'b1; tbl_addr = 8'd255; tbl_wdata = 32'd0; end
      if (poke && lat == 2) tbl_we = 1'b0;
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (rsp_valid) begin got = 1'b1; break; end
      if (req_ready) busy_ok = 1'b0;
    end
    req_valid = 1'b0;
    tbl_we = 1'b0;
    chk(got, req, "response seen", int'(got), 1);
    chk(rsp_found == e_f, req, "found", int'(rsp_found), int'(e_f));
    chk(rsp_chan == e_c, req, "channel", int'(rsp_chan), int'(e_c));
    chk(lat == e_lat, req, "latency", lat, e_lat);
    if (noise) begin
      chk(busy_ok, "R11", "ready low while busy", int'(busy_ok), 1);
      @(negedge clk);
      chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R11", "no extra response",
          int'(rsp_valid), 0);
    end
    if (poke) begin
      tbl_m[255] = 32'd0;
      for (int i = 0; i < 4096; i++) cv_m[i] = 1'b0;
    end else if (e_f) begin
      cv_m[id] = 1'b1; cc_m[id] = e_c;
    end
  endtask

  initial begin
    process::self().srandom(32'd17);
    for (int i = 0; i < 256; i++) tbl_m[i] = '0;
    for (int i = 0; i < 4096; i++) begin cv_m[i] = 1'b0; cc_m[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);

    for (int i = 0; i < 256; i++) twrite(i, 32'd0);
    // R3 R4 directed tree; upper bits set to show they are ignored
    twrite(0, mk(11, 1, 1, 0, 8'hA5) | 32'hFFC0_0000);
    twrite(1, mk(0, 0, 8'h11, 1, 2));
    twrite(2, mk(14, 0, 8'h33, 0, 8'h44));

    run_req(4'h8, 8'h00, 0, 0, "R3");   // bit 11 = 1 -> A5 in one node
    run_req(4'h0, 8'h00, 0, 0, "R4");   // node1 zero branch final
    run_req(4'h0, 8'h01, 0, 0, "R2");   // selector 14 reads 0 -> 0x33
    run_req(4'h0, 8'h01, 0, 0, "R7");   // cached, one cycle
    run_req(4'h1, 8'h01, 0, 0, "R2");   // sid in bits 11:8 not tested
    run_req(4'h8, 8'h00, 0, 0, "R7");   // cached
    twrite(200, 32'h1234);
    run_req(4'h8, 8'h00, 0, 0, "R9");   // invalidated, walks again
    run_req(4'h2, 8'h03, 1, 0, "R10");  // write during walk
    run_req(4'h2, 8'h03, 0, 0, "R10");  // not cached, walks again
    run_req(4'h0, 8'h01, 0, 0, "R9");   // poke cleared cache
    run_req(4'h0, 8'h00, 0, 1, "R11");  // requests held while busy

    // R6 self loop fails after 16 nodes
    twrite(0, mk(0, 1, 0, 1, 0));
    run_req(4'h3, 8'h05, 0, 0, "R6");
    run_req(4'h3, 8'h05, 0, 0, "R8");

    // R5 R6 exactly 16 nodes succeeds
    for (int k = 0; k < 15; k++) twrite(k, mk(12, 1, k + 1, 1, k + 1));
    twrite(15, mk(12, 0, 8'h77, 0, 8'h66));
    run_req(4'h5, 8'h5A, 0, 0, "R5");
    run_req(4'h5, 8'h5A, 0, 0, "R7");

    // random trees
    for (int i = 0; i < 32; i++)
      twrite(i, mk($urandom % 16, 1'($urandom), $urandom % 32, 1'($urandom), $urandom % 32));
    for (int j = 0; j < 80; j++) begin
      if ($urandom % 10 == 0)
        twrite($urandom % 32, mk($urandom % 16, 1'($urandom), $urandom % 32,
                                 1'($urandom), $urandom % 32));
      run_req(4'($urandom % 2), 8'($urandom % 8), 0, 0, "R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule